// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a 256-byte serial EEPROM that answers on a two-wire bus. Both bus lines are sampled from the system clock. The block finds START and STOP conditions and answers only to a device address byte whose upper bits carry a fixed type code and the values on three strap inputs. Up to eight such devices can share one bus. A word address byte sets an internal pointer. Data bytes that follow are collected in an 8-byte page buffer. A STOP commits them to the array in a single self-timed write.

Reads return the byte at the pointer and then advance the pointer. After every byte the master acknowledges, the block sends the next one. This gives random read, current-address read and sequential read. A write-protect input, when high, makes the whole array read-only. While a write cycle is running, the block refuses its own address, so a master can poll for completion. The SDA output is a pull-low enable only.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The block only ever pulls SDA low through `sda_pull_o`, which is 0 after reset. The enable changes only while the sampled SCL is low, except that a START or a STOP releases it.
- R2: The block acknowledges (pulls SDA low in the ninth clock) a device byte whose bits 7..1 equal 1010 followed by strap_i[2], strap_i[1], strap_i[0]. Bit 0 set to 1 selects a read. Any other device byte gets no acknowledge. A strap that is not driven counts as 0.
- R3: A write of one device byte, one word address and one data byte, closed by a STOP, stores that byte. A random read (write of device byte and address, repeated START, read of device byte) then returns it.
- R4: In a write, each data byte goes to the pointer's page slot, and then only the low 3 pointer bits advance, wrapping inside the 8-byte page. A ninth and later byte overwrites earlier slots of the same page.
- R5: In a read, the pointer advances over the full 8-bit range after each byte sent, wrapping from 255 to 0. Each byte the master acknowledges is followed by the byte at the next address.
- R6: A read started without a word address (current-address read) returns the byte at the address after the last byte accessed.
- R7: While `wp_i` is high, a write sequence leaves every stored byte unchanged and starts no write cycle.
- R8: After a committing STOP, the block does not acknowledge its device address for WRITE_CYCLES system clocks. After that it acknowledges again.
- R9: A STOP anywhere returns the block to idle. A START anywhere begins a new device byte. Data is committed only on a STOP that follows at least one complete data byte with no START in between.
- R10: When the master does not acknowledge a read byte, the block releases SDA and stays off the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Device address straps, undriven counts as 0 |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| sda_pull_o | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
A wrong bit counter or state shows up within one byte. The acknowledge lands in the wrong clock, or data bits come out shifted, and the next master read of the acknowledge or of the byte catches it. Pointer errors show up only on a later read. For that reason, page-wrap, full-address wrap and current-address reads are each read back over several bytes with values that differ per address. Write-cycle timing errors show up on the first address poll after a STOP. Protection and abort errors show up only as stale or altered data on a later random read.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } tw_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } tw_line_t;

    // A pin counts as set only when it is driven to a clean 1.
    function automatic logic pin_set(input logic b);
        return (b === 1'b1);
    endfunction

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler
    import tw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output tw_line_t line_o
);
    logic [1:0] scl_sy;
    logic [1:0] sda_sy;
    logic       scl_p;
    logic       sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_p  <= scl_sy[1];
            sda_p  <= sda_sy[1];
        end
    end

    always_comb begin
        line_o.scl   = scl_sy[1];
        line_o.sda   = sda_sy[1];
        line_o.rise  = scl_sy[1] & ~scl_p;
        line_o.fall  = ~scl_sy[1] & scl_p;
        line_o.start = scl_sy[1] & scl_p & sda_p & ~sda_sy[1];
        line_o.stop  = scl_sy[1] & scl_p & ~sda_p & sda_sy[1];
    end
endmodule

// File: rtl/tw_array.sv
module tw_array
    import tw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pb_clear,
    input  logic                     pb_we,
    input  logic [PAGE_W-1:0]        pb_idx,
    input  logic [BYTE_W-1:0]        pb_data,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_row,
    input  logic                     wp,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [BYTE_W-1:0] mem  [DEPTH];
    logic [BYTE_W-1:0] pbuf [PAGE];
    logic [PAGE-1:0]   pmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
        end else if (pb_clear || commit) begin
            pmask <= '0;
        end else if (pb_we) begin
            pmask[pb_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (pb_we) begin
            pbuf[pb_idx] <= pb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (commit && !wp) begin
            for (int j = 0; j < PAGE; j++) begin
                if (pmask[j]) begin
                    mem[{commit_row, PAGE_W'(j)}] <= pbuf[j];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 3,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);
    localparam int ROW_W  = ADDR_W - PAGE_W;

    tw_line_t             ln;
    tw_state_e            st;
    tw_state_e            nxt;
    logic [3:0]           bitcnt;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    tx;
    logic [ADDR_W-1:0]    ptr;
    logic                 got_data;
    logic                 mack;
    logic                 oe;
    logic [BUSY_W-1:0]    busy_cnt;
    logic                 pb_clear;
    logic                 pb_we;
    logic [PAGE_W-1:0]    pb_idx;
    logic [BYTE_W-1:0]    pb_data;
    logic                 commit;
    logic [BYTE_W-1:0]    rd_data;
    logic [2:0]           strap_v;
    logic                 wp_eff;

    assign strap_v = {pin_set(strap_i[2]), pin_set(strap_i[1]), pin_set(strap_i[0])};
    assign wp_eff  = pin_set(wp_i);

    tw_line_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .line_o (ln)
    );

    tw_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .pb_clear   (pb_clear),
        .pb_we      (pb_we),
        .pb_idx     (pb_idx),
        .pb_data    (pb_data),
        .commit     (commit),
        .commit_row (ptr[ADDR_W-1:PAGE_W]),
        .wp         (wp_eff),
        .rd_addr    (ptr),
        .rd_data    (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            nxt      <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            tx       <= '0;
            ptr      <= '0;
            got_data <= 1'b0;
            mack     <= 1'b0;
            oe       <= 1'b0;
            busy_cnt <= '0;
            pb_clear <= 1'b0;
            pb_we    <= 1'b0;
            pb_idx   <= '0;
            pb_data  <= '0;
            commit   <= 1'b0;
        end else begin
            pb_clear <= 1'b0;
            pb_we    <= 1'b0;
            commit   <= 1'b0;
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;

            if (ln.stop) begin
                oe       <= 1'b0;
                st       <= ST_IDLE;
                got_data <= 1'b0;
                if (got_data) begin
                    commit <= 1'b1;
                    if (!wp_eff) busy_cnt <= BUSY_W'(WRITE_CYCLES);
                end
            end else if (ln.start) begin
                oe       <= 1'b0;
                st       <= ST_DEV;
                bitcnt   <= '0;
                got_data <= 1'b0;
                pb_clear <= 1'b1;
            end else begin
                case (st)
                    ST_DEV, ST_ADDR, ST_WDATA: begin
                        if (ln.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ln.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ln.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            st     <= ST_ACK;
                            if (st == ST_DEV) begin
                                if (shreg[7:1] == {DEV_TYPE, strap_v} && busy_cnt == '0) begin
                                    oe  <= 1'b1;
                                    nxt <= shreg[0] ? ST_TX : ST_ADDR;
                                end else begin
                                    st <= ST_WAIT;
                                end
                            end else if (st == ST_ADDR) begin
                                ptr <= shreg[ADDR_W-1:0];
                                oe  <= 1'b1;
                                nxt <= ST_WDATA;
                            end else begin
                                pb_we    <= 1'b1;
                                pb_idx   <= ptr[PAGE_W-1:0];
                                pb_data  <= shreg;
                                ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                got_data <= 1'b1;
                                oe       <= 1'b1;
                                nxt      <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ln.fall) begin
                            if (nxt == ST_TX) begin
                                tx     <= rd_data;
                                oe     <= ~rd_data[7];
                                bitcnt <= 4'd1;
                            end else begin
                                oe     <= 1'b0;
                                bitcnt <= '0;
                            end
                            st <= nxt;
                        end
                    end
                    ST_TX: begin
                        if (ln.fall) begin
                            if (bitcnt != 4'd8) begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                oe     <= ~tx[6];
                                bitcnt <= bitcnt + 1'b1;
                            end else begin
                                oe  <= 1'b0;
                                ptr <= ptr + 1'b1;
                                st  <= ST_MACK;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ln.rise) begin
                            mack <= ~ln.sda;
                        end else if (ln.fall) begin
                            if (mack) begin
                                tx     <= rd_data;
                                oe     <= ~rd_data[7];
                                bitcnt <= 4'd1;
                                st     <= ST_TX;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    ST_IDLE, ST_WAIT: ;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_pull_o = oe;

    AST_PULL_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($past(ln.scl) && !$past(ln.start) && !$past(ln.stop)) |-> $stable(sda_pull_o)); // R1

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ln.stop |=> (st == ST_IDLE)); // R9

    AST_START_TO_DEV: assert property (@(posedge clk) disable iff (rst)
        (ln.start && !ln.stop) |=> (st == ST_DEV)); // R9

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= BUSY_W'(WRITE_CYCLES)); // R8

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && ln.fall && bitcnt == 4'd8 && busy_cnt > BUSY_W'(1)) |=> !sda_pull_o); // R8

    AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WDATA && !ln.start && !ln.stop) |=> $stable(ptr[ADDR_W-1:PAGE_W])); // R4

    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !ln.start) |=> !sda_pull_o); // R10

    if (ROW_W < 1) begin : g_bad_cfg
        initial AST_ROW_WIDTH: assert (ROW_W >= 1); // R4
    end
endmodule

// File: tb/tw_eeprom_slave_tb.sv
module tw_eeprom_slave_tb;
    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] strap = STRAP;
    logic wp = 1'b0;
    logic sda_pull;
    logic sda_bus;
    logic [7:0] rbuf [16];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    assign sda_bus = ~(m_low | sda_pull);

    tw_eeprom_slave #(.WRITE_CYCLES(600)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .wp_i       (wp),
        .sda_pull_o (sda_pull)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic bus_start();
        m_low = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        m_low = 1'b1; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        m_low = 1'b0; wt(2 * Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wt(Q);
            scl = 1'b1; wt(2 * Q);
            scl = 1'b0; wt(Q);
        end
        m_low = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        acked = ~sda_bus; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic rbyte(output logic [7:0] b, input logic master_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl = 1'b1; wt(Q);
            b[i] = sda_bus; wt(Q);
            scl = 1'b0; wt(Q);
        end
        m_low = master_ack; wt(Q);
        scl = 1'b1; wt(2 * Q);
        scl = 1'b0; wt(Q);
        m_low = 1'b0;
    endtask

    task automatic write_seq(input logic [7:0] addr, input int n, input logic [7:0] base, output int nacks);
        logic a;
        nacks = 0;
        bus_start();
        wbyte(dbyte(STRAP, 1'b0), a); if (!a) nacks++;
        wbyte(addr, a); if (!a) nacks++;
        for (int i = 0; i < n; i++) begin
            wbyte(base + 8'(i), a); if (!a) nacks++;
        end
        bus_stop();
    endtask

    task automatic poll_ready(output int tries);
        logic a;
        tries = 0;
        for (int k = 0; k < 60; k++) begin
            tries++;
            bus_start();
            wbyte(dbyte(STRAP, 1'b0), a);
            bus_stop();
            if (a) break;
        end
    endtask

    task automatic read_seq(input logic [7:0] addr, input int n);
        logic a;
        bus_start();
        wbyte(dbyte(STRAP, 1'b0), a);
        wbyte(addr, a);
        bus_start();
        wbyte(dbyte(STRAP, 1'b1), a);
        for (int i = 0; i < n; i++) rbyte(rbuf[i], (i != n - 1));
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 pull released after reset", sda_pull, 0);
        check("R1 bus idle high", sda_bus, 1);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        wbyte(dbyte(3'b000, 1'b0), a);
        bus_stop();
        check("R2 no ack for foreign address", a, 0);
        bus_start();
        wbyte(8'hB0 | {4'b0, STRAP, 1'b0}, a);
        bus_stop();
        check("R2 no ack for wrong type code", a, 0);
    endtask

    task automatic t_byte_write();
        int nk, tries;
        write_seq(8'h10, 1, 8'hA5, nk);
        check("R2 R3 all bytes acknowledged", nk, 0);
        poll_ready(tries);
        check("R8 busy after commit (polls > 1)", int'(tries > 1), 1);
        check("R8 ready within bound", int'(tries < 60), 1);
        read_seq(8'h10, 1);
        check("R3 random read of written byte", rbuf[0], 8'hA5);
    endtask

    task automatic t_page();
        int nk, tries;
        logic [7:0] exp [8];
        write_seq(8'h20, 8, 8'h30, nk);
        poll_ready(tries);
        read_seq(8'h20, 8);
        for (int i = 0; i < 8; i++) check("R4 R5 page then sequential read", rbuf[i], 8'h30 + i);
        write_seq(8'h46, 10, 8'h80, nk);
        poll_ready(tries);
        for (int i = 0; i < 10; i++) exp[(6 + i) % 8] = 8'h80 + 8'(i);
        read_seq(8'h40, 8);
        for (int i = 0; i < 8; i++) check("R4 page wrap overwrite", rbuf[i], exp[i]);
    endtask

    task automatic t_current();
        logic a;
        logic [7:0] d;
        read_seq(8'h20, 1);
        bus_start();
        wbyte(dbyte(STRAP, 1'b1), a);
        rbyte(d, 1'b0);
        bus_stop();
        check("R6 current address read", d, 8'h31);
    endtask

    task automatic t_wrap();
        int nk, tries;
        write_seq(8'hF8, 8, 8'hE0, nk);
        poll_ready(tries);
        write_seq(8'h00, 2, 8'h70, nk);
        poll_ready(tries);
        read_seq(8'hFE, 4);
        check("R5 wrap byte 254", rbuf[0], 8'hE6);
        check("R5 wrap byte 255", rbuf[1], 8'hE7);
        check("R5 wrap byte 0", rbuf[2], 8'h70);
        check("R5 wrap byte 1", rbuf[3], 8'h71);
    endtask

    task automatic t_protect();
        int nk, tries;
        wp = 1'b1;
        write_seq(8'h10, 1, 8'h3C, nk);
        poll_ready(tries);
        check("R7 no write cycle under protect", tries, 1);
        wp = 1'b0;
        read_seq(8'h10, 1);
        check("R7 protected byte unchanged", rbuf[0], 8'hA5);
    endtask

    task automatic t_abort();
        logic a;
        int tries;
        bus_start();
        wbyte(dbyte(STRAP, 1'b0), a);
        wbyte(8'h21, a);
        bus_stop();
        poll_ready(tries);
        check("R9 no commit without data byte", tries, 1);
        bus_start();
        wbyte(dbyte(STRAP, 1'b0), a);
        wbyte(8'h22, a);
        wbyte(8'h99, a);
        bus_start();
        bus_stop();
        poll_ready(tries);
        check("R9 START discards pending data", tries, 1);
        read_seq(8'h22, 1);
        check("R9 aborted byte not stored", rbuf[0], 8'h32);
    endtask

    task automatic t_nack();
        logic a;
        logic [7:0] d;
        bus_start();
        wbyte(dbyte(STRAP, 1'b0), a);
        wbyte(8'h20, a);
        bus_start();
        wbyte(dbyte(STRAP, 1'b1), a);
        rbyte(d, 1'b0);
        check("R10 byte before master nack", d, 8'h30);
        rbyte(d, 1'b0);
        check("R10 line released after nack", d, 8'hFF);
        check("R10 pull off", sda_pull, 0);
        bus_stop();
    endtask

    task automatic t_strap_float();
        logic a;
        strap = 3'bz1z;
        bus_start();
        wbyte(dbyte(3'b010, 1'b0), a);
        bus_stop();
        check("R2 undriven straps read as 0", a, 1);
        strap = STRAP;
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_wrong_addr();
        t_byte_write();
        t_page();
        t_current();
        t_wrap();
        t_protect();
        t_abort();
        t_nack();
        t_strap_float();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule